// File: doc/BRIEF.md
# Writeback Order Stall Controller

This block sits at the issue point of an in-order pipeline and holds back a candidate instruction whenever issuing it now would let one of its register results reach writeback before a result of an instruction issued earlier. It keeps a single countdown register. The register holds the number of cycles from the current cycle until the latest ordered write completes. When a candidate arrives, the block compares that countdown with the earliest of the candidate's own writeback times. The difference is the exact number of cycles the candidate has to wait.

Each candidate presents up to `NUM_DST` destinations. Every destination has a valid bit, a remaining-cycle code and a nominal latency. The candidate also carries an exemption flag that marks instructions allowed to complete out of order. The candidate enters through a valid/ready handshake. `cand_ready` is the issue-permitted signal and `cand_stall` is the computed wait. Both are combinational from the countdown and the candidate fields. Neither depends on `cand_valid`, so upstream logic may look at them before it asserts valid. An issue takes place only on a cycle where both `cand_valid` and `cand_ready` are high. Without that handshake the countdown keeps counting down and does nothing else. While `cand_ready` is low the upstream stage must hold its candidate. Upstream may also withdraw the candidate; nothing is recorded until an issue takes place.

Top module: `wbo_stall_ctrl`

## Requirements
- R1: After reset the countdown is zero, so any candidate sees `cand_stall` = 0 and `cand_ready` = 1.
- R2: On every clock edge without an ordered issue, a nonzero countdown drops by exactly one, and a zero countdown stays at zero.
- R3: A candidate with `cand_ooo` = 1, or any candidate while the countdown is zero, gets `cand_stall` = 0 and `cand_ready` = 1.
- R4: A candidate's earliest writeback is the minimum effective remaining-cycle value over its valid destinations only. With no valid destination it is 63 (all ones), so that candidate never stalls.
- R5: When ordering applies and the earliest writeback is below the countdown, `cand_stall` equals the countdown minus that earliest value. Otherwise `cand_stall` is 0. `cand_ready` is high exactly when `cand_stall` is 0, and a held candidate is released after `cand_stall` cycles.
- R6: An ordered issue (`cand_valid` & `cand_ready` & !`cand_ooo`) loads the countdown with the maximum effective remaining-cycle value over the valid destinations, or 0 with none valid. The load takes priority over the decrement on the same edge.
- R7: An issue with `cand_ooo` = 1 leaves the countdown to decrement as if no issue had happened.
- R8: Destination i uses bits [6i+5:6i] of `dst_rem` and `dst_lat`. A remaining code of 6'h3F means unknown, and the nominal latency `dst_lat` is used in its place. Codes 6'h20 to 6'h3E are negative two's-complement values and count as 0. Codes 6'h00 to 6'h1F are used as they are.
- R9: With `cand_valid` = 0 no issue takes place, whatever `cand_ready` is, and the countdown only decays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate instruction is offered |
| cand_ready | output | 1 | Issue permitted for the offered candidate |
| cand_ooo | input | 1 | Candidate is exempt from write ordering |
| dst_vld | input | NUM_DST | Per-destination valid bits |
| dst_rem | input | NUM_DST*LAT_W | Per-destination remaining-cycle codes |
| dst_lat | input | NUM_DST*LAT_W | Per-destination nominal latencies |
| cand_stall | output | LAT_W | Cycles the candidate must still wait |

## Verification
The properties assume that upstream honours the handshake. They also assume that a candidate held through a stall keeps the same destination fields; the shrinking-stall property is guarded on those fields being stable. Nominal latencies are taken to be plain unsigned counts that fit in six bits. The directed tasks drive every field at the falling edge. They keep a stalled candidate unchanged until it issues, and they read the countdown only through a probe candidate: one valid destination with remaining code 0 and no exemption. For such a probe `cand_stall` equals the countdown.

// File: rtl/wbo_pkg.sv
package wbo_pkg;
  typedef enum logic [1:0] {
    REM_PLAIN   = 2'd0,
    REM_UNKNOWN = 2'd1,
    REM_NEG     = 2'd2
  } rem_kind_e;
endpackage

// File: rtl/wbo_dest_norm.sv
module wbo_dest_norm
  import wbo_pkg::*;
#(
  parameter int LAT_W = 6
) (
  input  logic [LAT_W-1:0] rem,
  input  logic [LAT_W-1:0] lat,
  output logic [LAT_W-1:0] eff
);
  localparam logic [LAT_W-1:0] UNKNOWN_CODE = '1;

  rem_kind_e kind;

  always_comb begin
    if (rem == UNKNOWN_CODE)   kind = REM_UNKNOWN;
    else if (rem[LAT_W-1])     kind = REM_NEG;
    else                       kind = REM_PLAIN;
  end

  always_comb begin
    unique case (kind)
      REM_UNKNOWN: eff = lat;
      REM_NEG:     eff = '0;
      default:     eff = rem;
    endcase
  end
endmodule

// File: rtl/wbo_reduce.sv
module wbo_reduce #(
  parameter int NUM_DST = 4,
  parameter int LAT_W   = 6
) (
  input  logic [NUM_DST-1:0]       vld,
  input  logic [NUM_DST*LAT_W-1:0] eff,
  output logic [LAT_W-1:0]         first_wb,
  output logic [LAT_W-1:0]         last_wb
);
  always_comb begin
    first_wb = '1;
    last_wb  = '0;
    for (int i = 0; i < NUM_DST; i++) begin
      if (vld[i]) begin
        if (eff[i*LAT_W +: LAT_W] < first_wb) first_wb = eff[i*LAT_W +: LAT_W];
        if (eff[i*LAT_W +: LAT_W] > last_wb)  last_wb  = eff[i*LAT_W +: LAT_W];
      end
    end
  end
endmodule

// File: rtl/wbo_countdown.sv
module wbo_countdown #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic [LAT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (load)       count <= load_val;
    else if (count != 0) count <= count - 1'b1;
  end
endmodule

// File: rtl/wbo_stall_ctrl.sv
module wbo_stall_ctrl #(
  parameter int NUM_DST = 4,
  parameter int LAT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cand_valid,
  output logic                     cand_ready,
  input  logic                     cand_ooo,
  input  logic [NUM_DST-1:0]       dst_vld,
  input  logic [NUM_DST*LAT_W-1:0] dst_rem,
  input  logic [NUM_DST*LAT_W-1:0] dst_lat,
  output logic [LAT_W-1:0]         cand_stall
);
  localparam int FLAT_W = NUM_DST * LAT_W;

  logic [FLAT_W-1:0] eff_flat;
  logic [LAT_W-1:0]  first_wb;
  logic [LAT_W-1:0]  last_wb;
  logic [LAT_W-1:0]  count_q;
  logic              order_chk;
  logic              load_en;

  for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
    wbo_dest_norm #(.LAT_W(LAT_W)) u_norm (
      .rem (dst_rem[g*LAT_W +: LAT_W]),
      .lat (dst_lat[g*LAT_W +: LAT_W]),
      .eff (eff_flat[g*LAT_W +: LAT_W])
    );
  end

  wbo_reduce #(.NUM_DST(NUM_DST), .LAT_W(LAT_W)) u_reduce (
    .vld      (dst_vld),
    .eff      (eff_flat),
    .first_wb (first_wb),
    .last_wb  (last_wb)
  );

  // Ordering applies only to non-exempt candidates while a write is pending.
  assign order_chk = (count_q != '0) && !cand_ooo;

  always_comb begin
    if (order_chk && (first_wb < count_q)) cand_stall = count_q - first_wb;
    else                                   cand_stall = '0;
  end

  assign cand_ready = (cand_stall == '0);
  assign load_en    = cand_valid && cand_ready && !cand_ooo;

  wbo_countdown #(.LAT_W(LAT_W)) u_cd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_en),
    .load_val (last_wb),
    .count    (count_q)
  );
endmodule

// File: rtl/wbo_stall_chk.sv
module wbo_stall_chk #(
  parameter int NUM_DST = 4,
  parameter int LAT_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cand_valid,
  input logic                     cand_ready,
  input logic                     cand_ooo,
  input logic [NUM_DST-1:0]       dst_vld,
  input logic [NUM_DST*LAT_W-1:0] dst_rem,
  input logic [NUM_DST*LAT_W-1:0] dst_lat,
  input logic [LAT_W-1:0]         cand_stall,
  input logic [LAT_W-1:0]         count,
  input logic [LAT_W-1:0]         last_wb
);
  logic ord_issue;
  assign ord_issue = cand_valid && cand_ready && !cand_ooo;

  // R2: a pending countdown decays by one without an ordered issue
  assert_decay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ord_issue && count != '0) |=> count == LAT_W'($past(count) - 1'b1));

  // R2: zero stays zero
  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ord_issue && count == '0) |=> count == '0);

  // R3: exempt candidates never wait
  assert_exempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ooo |-> (cand_ready && cand_stall == '0));

  // R3: nothing pending means free issue
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> cand_ready);

  // R5: a held candidate waits one cycle less each cycle
  assert_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_stall != '0) |=> (!$stable(dst_vld) || !$stable(dst_rem) ||
                            !$stable(dst_lat) || !$stable(cand_ooo) ||
                            cand_stall == LAT_W'($past(cand_stall) - 1'b1)));

  // R6: ordered issue loads the latest writeback
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ord_issue |=> count == $past(last_wb));

  // R5: a stalled candidate is never ready
  assert_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_stall != '0) |-> !cand_ready);
endmodule

bind wbo_stall_ctrl wbo_stall_chk #(.NUM_DST(NUM_DST), .LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .cand_ready (cand_ready),
  .cand_ooo   (cand_ooo),
  .dst_vld    (dst_vld),
  .dst_rem    (dst_rem),
  .dst_lat    (dst_lat),
  .cand_stall (cand_stall),
  .count      (count_q),
  .last_wb    (last_wb)
);

// File: tb/sim_wbo_stall_ctrl.sv
module sim_wbo_stall_ctrl;
  localparam int ND = 4;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cand_valid = 1'b0;
  logic          cand_ooo = 1'b0;
  logic [ND-1:0] dst_vld = '0;
  logic [ND*LW-1:0] dst_rem = '0;
  logic [ND*LW-1:0] dst_lat = '0;
  logic          cand_ready;
  logic [LW-1:0] cand_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wbo_stall_ctrl #(.NUM_DST(ND), .LAT_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_ooo(cand_ooo), .dst_vld(dst_vld), .dst_rem(dst_rem), .dst_lat(dst_lat),
    .cand_stall(cand_stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    dst_vld = '0; dst_rem = '0; dst_lat = '0; cand_ooo = 1'b0; cand_valid = 1'b0;
  endtask

  task automatic set_d(input int i, input logic [LW-1:0] rem, input logic [LW-1:0] lat);
    dst_vld[i] = 1'b1;
    dst_rem[i*LW +: LW] = rem;
    dst_lat[i*LW +: LW] = lat;
  endtask

  // Probe: one valid destination at 0, no exemption: stall equals countdown.
  task automatic probe(input string req, input int exp);
    clr(); set_d(0, 6'd0, 6'd0);
    #1 chk(req, cand_stall, exp);
  endtask

  // Leaves the caller just after a falling edge with the countdown equal to v.
  task automatic load_cd(input logic [LW-1:0] v);
    @(negedge clk); clr(); cand_valid = 1'b1;
    @(negedge clk); clr(); set_d(0, v, 6'd0); cand_valid = 1'b1;
    @(negedge clk); clr();
  endtask

  task automatic t_reset();
    @(negedge clk);
    clr(); set_d(0, 6'd2, 6'd0); set_d(1, 6'd7, 6'd0);
    #1 chk("R1 stall", cand_stall, 0);
    chk("R1 ready", cand_ready, 1);
  endtask

  task automatic t_decay();
    load_cd(6'd4);
    probe("R9 no issue without valid", 4);
    for (int k = 3; k >= 0; k--) begin
      @(negedge clk); probe("R2 decay", k);
    end
    @(negedge clk); probe("R2 floor", 0);
  endtask

  task automatic t_first();
    load_cd(6'd5);
    clr(); set_d(0, 6'd7, 6'd0); set_d(2, 6'd3, 6'd0); set_d(3, 6'd1, 6'd0);
    dst_vld[3] = 1'b0;
    #1 chk("R4 min over valid", cand_stall, 2);
    chk("R5 not ready", cand_ready, 0);
    clr(); set_d(1, 6'd6, 6'd0);
    #1 chk("R5 late enough", cand_stall, 0);
    clr(); set_d(1, 6'd5, 6'd0);
    #1 chk("R5 equal", cand_stall, 0);
    clr();
    #1 chk("R4 no dests", cand_stall, 0);
    cand_valid = 1'b1;
    @(negedge clk); probe("R6 empty load", 0);
  endtask

  task automatic t_ooo();
    load_cd(6'd5);
    clr(); set_d(0, 6'd1, 6'd0); cand_ooo = 1'b1;
    #1 chk("R3 exempt stall", cand_stall, 0);
    chk("R3 exempt ready", cand_ready, 1);
    set_d(1, 6'd20, 6'd0); cand_valid = 1'b1;
    @(negedge clk); probe("R7 exempt issue keeps decay", 4);
  endtask

  task automatic t_codes();
    load_cd(6'd5);
    clr(); set_d(0, 6'h3F, 6'd9); cand_valid = 1'b1;
    #1 chk("R8 unknown uses latency", cand_stall, 0);
    @(negedge clk); probe("R8 unknown loaded", 9);
    clr(); set_d(0, 6'h30, 6'd0);
    #1 chk("R8 negative clamps", cand_stall, 9);
    clr(); set_d(0, 6'h3F, 6'd2);
    #1 chk("R8 unknown as first", cand_stall, 7);
  endtask

  task automatic t_release();
    load_cd(6'd5);
    clr(); set_d(0, 6'd2, 6'd0); set_d(1, 6'd3, 6'd0); cand_valid = 1'b1;
    for (int k = 3; k >= 1; k--) begin
      #1 chk("R5 held stall", cand_stall, k);
      @(negedge clk);
    end
    #1 chk("R5 released", cand_ready, 1);
    @(negedge clk); probe("R6 load after release", 3);
  endtask

  task automatic t_prio();
    load_cd(6'd5);
    clr(); set_d(0, 6'd8, 6'd0); cand_valid = 1'b1;
    @(negedge clk); probe("R6 load over decrement", 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decay();
    t_first();
    t_ooo();
    t_codes();
    t_release();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule